// File: doc/BRIEF.md
# Frame-Valid Generator With Dark Rows

This block produces the frame-level readout timing of an image sensor. A row-start strobe marks the start of each row period. A start-of-frame qualifier on that strobe begins a frame. For every row period the block then reports whether the frame is active (`fv_o`), which physical array row is being read out (`row_idx_o`), and a 2-bit tag that gives the kind of row.

In the normal mode only the programmed visible window appears in the frame. In the calibration-view mode the optically black rows are also shown. Frame-valid then rises earlier and stays high longer, and the frame carries, in order: a selectable tail of the black rows (the last shown is always the highest black row), two margin rows just above the window start, and then the visible rows. The mode and window settings are captured when a frame starts, so writes made during a frame only apply to the next one.

Top module: `fvg_frame_gen`

## Requirements
- R1: After reset, `fv_o` is 0, `row_tag_o` is 2'b00 and `row_idx_o` is 0.
- R2: A `row_stb_i` pulse with `sof_i` high while no frame is active starts a frame. With `dark_en_i` = 0 the frame shows rows `win_start_i` to `win_start_i + win_rows_i`, one per strobe in ascending order, each tagged 2'b11 (visible). `win_rows_i` holds the number of visible rows minus one.
- R3: `fv_o` falls on the strobe that follows the last visible row. While `fv_o` is 0, the tag is 2'b00 and the row index is 0.
- R4: With `dark_en_i` = 1 the frame is, in order: the black rows tagged 2'b01, then rows `win_start_i - 2` and `win_start_i - 1` tagged 2'b10 (margin), then the visible rows as in R2.
- R5: A dark-row field value k shows k+1 black rows, namely rows 7-k to 7 in ascending order. k = 7 shows rows 0 to 7 and k = 0 shows only row 7.
- R6: The mode, field, window start and row count are sampled only on the strobe that starts a frame. A change made during a frame leaves that frame unchanged and applies to the next frame.
- R7: `sof_i` has no effect while a frame is active, and `sof_i` without `row_stb_i` starts nothing.
- R8: Row indices wrap modulo 2^ROW_W. A window start below 2 gives margin rows at the top of the index range, and a window that runs past the last index continues from 0.
- R9: The outputs change only 1 + REG_OUT clock cycles after a strobe is sampled, and they hold steady at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_i | input | 1 | Row-start strobe, one cycle wide |
| sof_i | input | 1 | Start-of-frame qualifier for the row strobe |
| dark_en_i | input | 1 | Show the black rows in the frame |
| dark_sel_i | input | SEL_W | Number of black rows shown, minus one |
| win_start_i | input | ROW_W | First visible row |
| win_rows_i | input | CNT_W | Number of visible rows, minus one |
| fv_o | output | 1 | Frame valid |
| row_idx_o | output | ROW_W | Array row of the current row period |
| row_tag_o | output | 2 | 00 none, 01 dark, 10 margin, 11 visible |

## Verification
The bench builds the block with ROW_W = 8, CNT_W = 6 and REG_OUT = 1, and keeps the eight black rows and two margin rows. The narrow row index lets the bench test both wrap cases directly: margins below row 0 and a window that runs past row 255. The registered output stage lets it check the two-cycle latency after a strobe. Short windows keep each frame to a few strobes, so several dark-field values, a mid-frame settings change and stray start-of-frame pulses can all be tested in one run.

// File: rtl/fvg_pkg.sv
package fvg_pkg;
   typedef enum logic [1:0] {
      TAG_NONE   = 2'b00,
      TAG_DARK   = 2'b01,
      TAG_MARGIN = 2'b10,
      TAG_VIS    = 2'b11
   } row_tag_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_DARK,
      PH_MARGIN,
      PH_VIS
   } phase_e;
endpackage

// File: rtl/fvg_cfg_latch.sv
module fvg_cfg_latch #(
   parameter int ROW_W = 11,
   parameter int CNT_W = 11,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEL_W-1:0] dark_sel_i,
   input  logic [ROW_W-1:0] win_start_i,
   input  logic [CNT_W-1:0] win_rows_i,
   output logic [SEL_W-1:0] dark_sel_q,
   output logic [ROW_W-1:0] win_start_q,
   output logic [CNT_W-1:0] win_rows_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dark_sel_q  <= '0;
         win_start_q <= '0;
         win_rows_q  <= '0;
      end else if (load) begin
         dark_sel_q  <= dark_sel_i;
         win_start_q <= win_start_i;
         win_rows_q  <= win_rows_i;
      end
   end
endmodule

// File: rtl/fvg_seq.sv
module fvg_seq
   import fvg_pkg::*;
#(
   parameter int CNT_W       = 11,
   parameter int SEL_W       = 3,
   parameter int MARGIN_ROWS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_stb_i,
   input  logic             sof_i,
   input  logic             dark_en_i,
   input  logic [SEL_W-1:0] dark_sel_q,
   input  logic [CNT_W-1:0] win_rows_q,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             start_o
);
   localparam logic [CNT_W-1:0] MARGIN_LAST = CNT_W'(MARGIN_ROWS - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;

   assign start_o = row_stb_i && sof_i && (phase_q == PH_IDLE);
   assign phase_o = phase_q;
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (row_stb_i) begin
         case (phase_q)
            PH_IDLE: begin
               if (sof_i) begin
                  phase_q <= dark_en_i ? PH_DARK : PH_VIS;
                  cnt_q   <= '0;
               end
            end
            PH_DARK: begin
               if (cnt_q == CNT_W'(dark_sel_q)) begin
                  phase_q <= PH_MARGIN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_MARGIN: begin
               if (cnt_q == MARGIN_LAST) begin
                  phase_q <= PH_VIS;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == win_rows_q) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/fvg_row_map.sv
module fvg_row_map
   import fvg_pkg::*;
#(
   parameter int ROW_W       = 11,
   parameter int CNT_W       = 11,
   parameter int SEL_W       = 3,
   parameter int DARK_ROWS   = 8,
   parameter int MARGIN_ROWS = 2
) (
   input  phase_e           phase_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEL_W-1:0] dark_sel_q,
   input  logic [ROW_W-1:0] win_start_q,
   output logic             fv_o,
   output logic [1:0]       tag_o,
   output logic [ROW_W-1:0] idx_o
);
   localparam logic [ROW_W-1:0] DARK_TOP  = ROW_W'(DARK_ROWS - 1);
   localparam logic [ROW_W-1:0] MARGIN_SZ = ROW_W'(MARGIN_ROWS);

   logic [ROW_W-1:0] cnt_ext;
   assign cnt_ext = ROW_W'(cnt_i);

   always_comb begin
      fv_o  = 1'b1;
      tag_o = TAG_NONE;
      idx_o = '0;
      case (phase_i)
         PH_DARK: begin
            tag_o = TAG_DARK;
            idx_o = DARK_TOP - ROW_W'(dark_sel_q) + cnt_ext;
         end
         PH_MARGIN: begin
            tag_o = TAG_MARGIN;
            idx_o = win_start_q - MARGIN_SZ + cnt_ext;
         end
         PH_VIS: begin
            tag_o = TAG_VIS;
            idx_o = win_start_q + cnt_ext;
         end
         default: fv_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/fvg_frame_gen.sv
module fvg_frame_gen
   import fvg_pkg::*;
#(
   parameter int ROW_W       = 11,
   parameter int CNT_W       = 11,
   parameter int DARK_ROWS   = 8,
   parameter int MARGIN_ROWS = 2,
   parameter int REG_OUT     = 0,
   localparam int SEL_W      = $clog2(DARK_ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_stb_i,
   input  logic             sof_i,
   input  logic             dark_en_i,
   input  logic [SEL_W-1:0] dark_sel_i,
   input  logic [ROW_W-1:0] win_start_i,
   input  logic [CNT_W-1:0] win_rows_i,
   output logic             fv_o,
   output logic [ROW_W-1:0] row_idx_o,
   output logic [1:0]       row_tag_o
);
   generate
      if (DARK_ROWS < 2 || DARK_ROWS != (1 << SEL_W)) begin : g_bad_dark
         $error("DARK_ROWS must be a power of two of at least 2");
      end
      if (CNT_W < SEL_W || CNT_W > ROW_W) begin : g_bad_cnt
         $error("CNT_W must lie between SEL_W and ROW_W");
      end
      if (MARGIN_ROWS < 1 || MARGIN_ROWS > (1 << SEL_W)) begin : g_bad_margin
         $error("MARGIN_ROWS out of range");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("REG_OUT must be 0 or 1");
      end
   endgenerate

   phase_e           phase;
   logic [CNT_W-1:0] cnt;
   logic             start;
   logic [SEL_W-1:0] dark_sel_q;
   logic [ROW_W-1:0] win_start_q;
   logic [CNT_W-1:0] win_rows_q;
   logic             fv_c;
   logic [1:0]       tag_c;
   logic [ROW_W-1:0] idx_c;

   fvg_cfg_latch #(.ROW_W(ROW_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (start),
      .dark_sel_i  (dark_sel_i),
      .win_start_i (win_start_i),
      .win_rows_i  (win_rows_i),
      .dark_sel_q  (dark_sel_q),
      .win_start_q (win_start_q),
      .win_rows_q  (win_rows_q)
   );

   fvg_seq #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MARGIN_ROWS(MARGIN_ROWS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .row_stb_i  (row_stb_i),
      .sof_i      (sof_i),
      .dark_en_i  (dark_en_i),
      .dark_sel_q (dark_sel_q),
      .win_rows_q (win_rows_q),
      .phase_o    (phase),
      .cnt_o      (cnt),
      .start_o    (start)
   );

   fvg_row_map #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .SEL_W(SEL_W),
      .DARK_ROWS(DARK_ROWS), .MARGIN_ROWS(MARGIN_ROWS)
   ) u_map (
      .phase_i     (phase),
      .cnt_i       (cnt),
      .dark_sel_q  (dark_sel_q),
      .win_start_q (win_start_q),
      .fv_o        (fv_c),
      .tag_o       (tag_c),
      .idx_o       (idx_c)
   );

   generate
      if (REG_OUT == 1) begin : g_out_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               fv_o      <= 1'b0;
               row_tag_o <= TAG_NONE;
               row_idx_o <= '0;
            end else begin
               fv_o      <= fv_c;
               row_tag_o <= tag_c;
               row_idx_o <= idx_c;
            end
         end
      end else begin : g_out_comb
         assign fv_o      = fv_c;
         assign row_tag_o = tag_c;
         assign row_idx_o = idx_c;
      end
   endgenerate
endmodule

// File: rtl/fvg_frame_gen_chk.sv
module fvg_frame_gen_chk #(
   parameter int ROW_W     = 11,
   parameter int DARK_ROWS = 8,
   parameter int REG_OUT   = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             row_stb_i,
   input logic             fv_o,
   input logic [ROW_W-1:0] row_idx_o,
   input logic [1:0]       row_tag_o
);
   logic stb_d1, stb_d2, stb_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_d1 <= 1'b0;
         stb_d2 <= 1'b0;
      end else begin
         stb_d1 <= row_stb_i;
         stb_d2 <= stb_d1;
      end
   end
   assign stb_lat = (REG_OUT == 1) ? stb_d2 : stb_d1;

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_lat |-> ($stable(fv_o) && $stable(row_tag_o) && $stable(row_idx_o))); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !fv_o |-> (row_tag_o == 2'b00 && row_idx_o == '0)); // R3

   AST_ACTIVE_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      fv_o |-> (row_tag_o != 2'b00)); // R2

   AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fv_o) |-> (row_tag_o == 2'b01 || row_tag_o == 2'b11)); // R4

   AST_VIS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (row_tag_o == 2'b11) |=> (row_tag_o == 2'b11 || row_tag_o == 2'b00)); // R4

   AST_NO_DARK_AFTER_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
      (row_tag_o == 2'b10) |=> (row_tag_o != 2'b01)); // R4

   AST_DARK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (row_tag_o == 2'b01) |-> (row_idx_o < ROW_W'(DARK_ROWS))); // R5

   AST_DARK_ENDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(row_tag_o) == 2'b01 && row_tag_o == 2'b10)
         |-> ($past(row_idx_o) == ROW_W'(DARK_ROWS - 1))); // R5
endmodule

bind fvg_frame_gen fvg_frame_gen_chk #(
   .ROW_W(ROW_W), .DARK_ROWS(DARK_ROWS), .REG_OUT(REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_stb_i (row_stb_i),
   .fv_o      (fv_o),
   .row_idx_o (row_idx_o),
   .row_tag_o (row_tag_o)
);

// File: tb/test_fvg_frame_gen.sv
module test_fvg_frame_gen;
   localparam int ROW_W = 8;
   localparam int CNT_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             row_stb = 1'b0;
   logic             sof = 1'b0;
   logic             dark_en = 1'b0;
   logic [2:0]       dark_sel = '0;
   logic [ROW_W-1:0] win_start = '0;
   logic [CNT_W-1:0] win_rows = '0;
   logic             fv;
   logic [ROW_W-1:0] row_idx;
   logic [1:0]       row_tag;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   fvg_frame_gen #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .DARK_ROWS(8), .MARGIN_ROWS(2), .REG_OUT(1)
   ) i_fvg_frame_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .row_stb_i   (row_stb),
      .sof_i       (sof),
      .dark_en_i   (dark_en),
      .dark_sel_i  (dark_sel),
      .win_start_i (win_start),
      .win_rows_i  (win_rows),
      .fv_o        (fv),
      .row_idx_o   (row_idx),
      .row_tag_o   (row_tag)
   );

   task automatic expect_row(input logic efv, input logic [1:0] etag,
                             input logic [ROW_W-1:0] eidx, input string req);
      n_chk++;
      if (fv !== efv || row_tag !== etag || row_idx !== eidx) begin
         n_bad++;
         $display("FAIL %s: fv/tag/idx = %0b/%0d/%0d, expected %0b/%0d/%0d",
                  req, fv, row_tag, row_idx, efv, etag, eidx);
      end
   endtask

   // Pulse the strobe; return at the falling edge after the two-cycle output latency.
   task automatic pulse(input logic with_sof);
      @(negedge clk);
      row_stb = 1'b1;
      sof     = with_sof;
      @(negedge clk);
      row_stb = 1'b0;
      sof     = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic run_frame(input bit den, input int sel, input int start,
                            input int rows_m1, input string req);
      dark_en   = den;
      dark_sel  = 3'(sel);
      win_start = ROW_W'(start);
      win_rows  = CNT_W'(rows_m1);
      pulse(1'b1);
      if (den) begin
         for (int i = 0; i <= sel; i++) begin
            if (i > 0) pulse(1'b0);
            expect_row(1'b1, 2'b01, ROW_W'(7 - sel + i), req);
         end
         for (int i = 0; i < 2; i++) begin
            pulse(1'b0);
            expect_row(1'b1, 2'b10, ROW_W'(start - 2 + i), req);
         end
         pulse(1'b0);
      end
      for (int i = 0; i <= rows_m1; i++) begin
         if (i > 0) pulse(1'b0);
         expect_row(1'b1, 2'b11, ROW_W'(start + i), req);
      end
      pulse(1'b0);
      expect_row(1'b0, 2'b00, '0, "R3");
   endtask

   task automatic t_reset;
      expect_row(1'b0, 2'b00, '0, "R1");
   endtask

   task automatic t_normal;
      run_frame(1'b0, 0, 10, 3, "R2");
      run_frame(1'b0, 0, 100, 0, "R2");
   endtask

   task automatic t_dark;
      run_frame(1'b1, 7, 20, 1, "R4");
      run_frame(1'b1, 0, 5, 2, "R5");
      run_frame(1'b1, 3, 40, 0, "R5");
   endtask

   task automatic t_wrap;
      run_frame(1'b1, 1, 0, 1, "R8");
      run_frame(1'b0, 0, 254, 3, "R8");
   endtask

   task automatic t_latency;
      dark_en = 1'b0; win_start = 8'd60; win_rows = 6'd1;
      @(negedge clk);
      row_stb = 1'b1; sof = 1'b1;
      @(negedge clk);
      row_stb = 1'b0; sof = 1'b0;
      expect_row(1'b0, 2'b00, '0, "R9");
      @(negedge clk);
      expect_row(1'b1, 2'b11, 8'd60, "R9");
      repeat (5) @(negedge clk);
      expect_row(1'b1, 2'b11, 8'd60, "R9");
      pulse(1'b0);
      expect_row(1'b1, 2'b11, 8'd61, "R9");
      pulse(1'b0);
      expect_row(1'b0, 2'b00, '0, "R9");
   endtask

   task automatic t_midframe;
      dark_en = 1'b0; dark_sel = 3'd0; win_start = 8'd30; win_rows = 6'd1;
      pulse(1'b1);
      expect_row(1'b1, 2'b11, 8'd30, "R6");
      dark_en = 1'b1; dark_sel = 3'd2; win_start = 8'd50; win_rows = 6'd0;
      pulse(1'b0);
      expect_row(1'b1, 2'b11, 8'd31, "R6");
      pulse(1'b0);
      expect_row(1'b0, 2'b00, '0, "R6");
      pulse(1'b1);
      expect_row(1'b1, 2'b01, 8'd5, "R6");
      for (int i = 0; i < 5; i++) pulse(1'b0);
      expect_row(1'b1, 2'b11, 8'd50, "R6");
      pulse(1'b0);
      expect_row(1'b0, 2'b00, '0, "R6");
   endtask

   task automatic t_stray_sof;
      dark_en = 1'b0; win_start = 8'd70; win_rows = 6'd2;
      pulse(1'b1);
      expect_row(1'b1, 2'b11, 8'd70, "R7");
      pulse(1'b1);
      expect_row(1'b1, 2'b11, 8'd71, "R7");
      pulse(1'b1);
      expect_row(1'b1, 2'b11, 8'd72, "R7");
      pulse(1'b0);
      expect_row(1'b0, 2'b00, '0, "R7");
      @(negedge clk);
      sof = 1'b1;
      repeat (4) @(negedge clk);
      sof = 1'b0;
      repeat (2) @(negedge clk);
      expect_row(1'b0, 2'b00, '0, "R7");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset;
      t_normal;
      t_dark;
      t_wrap;
      t_latency;
      t_midframe;
      t_stray_sof;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule